// File: doc/BRIEF.md
# Two-Partition Frequency/Recency Replacement Controller

This block decides placement and eviction for a small content cache that is divided into a protected region and an open region. Each access carries a content identifier. The block looks the identifier up against the identifiers it holds for every slot. On a miss it picks the open-region slot that receives the new content. On a hit it updates its replacement state. The protected region is ordered by recency. Each open-region slot has a small saturating use counter, so the open region tracks approximate popularity. All counters are halved at fixed intervals so that old popularity fades.

When an open-region entry becomes popular enough that its counter saturates, the entry moves into the protected region. The protected slot it takes is the first empty one, or if none is empty, the least recently used one. The entry that leaves the protected region is not dropped: it moves into the open-region slot that was just vacated. The block reports each decision one cycle after the access: hit or miss, the region, the slot, whether a promotion happened, and the identifier of any content that was evicted or demoted. The data storage itself sits outside the block, and the block's outputs steer it.

Top module: `lfru_ctrl`

## Requirements
- R1: After reset every slot is empty, the access counter is zero and res_valid is 0. The first miss after reset fills flat slot 4 (open slot 0) and reports no eviction.
- R2: Every access with acc_valid high produces exactly one result, with res_valid high, on the clock edge that samples the access. A cycle without an access gives res_valid 0.
- R3: A miss always fills an open-region slot. The block picks the slot with the lowest counter, treating empty slots as 0, and the lowest index wins a tie. The new counter is 1. If the replaced slot held content, res_evict is 1 and res_out_id carries the old identifier. res_evict is never 1 on a hit.
- R4: A hit in the open region adds one to that slot's counter. The counter range is 0 to 7.
- R5: A hit that would bring an open counter to 7 promotes the entry. It moves to the lowest-index empty protected slot, or to the least recently used protected slot if none is empty. res_promote is 1 and res_slot gives the protected slot.
- R6: On a promotion, the protected entry that was displaced moves into the vacated open slot with counter 1, and res_demote and res_out_id report it. If the displaced protected slot was empty, the vacated open slot becomes empty.
- R7: A hit in the protected region (res_in_priv 1) makes that slot the most recently used and leaves the open counters unchanged.
- R8: On every 64th access since reset, all open counters are halved (rounding down) after that access's own update.
- R9: An identifier is held in at most one slot across both regions.
- R10: Flat slot numbering is 0 to 3 for protected slots and 4 to 11 for open slots 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_id | input | 16 | Content identifier of the access |
| res_valid | output | 1 | Result of the access sampled on the previous edge |
| res_hit | output | 1 | The identifier was held in some slot |
| res_in_priv | output | 1 | The hit was in the protected region |
| res_slot | output | 4 | Flat slot touched, filled or promoted into |
| res_promote | output | 1 | The access promoted an open entry |
| res_evict | output | 1 | A miss replaced held content |
| res_demote | output | 1 | A promotion pushed a protected entry into the open region |
| res_out_id | output | 16 | Identifier that was evicted or demoted, else 0 |

## Verification
Every result is registered once. It is due on the same rising edge that samples acc_valid, so the bench drives each access on a falling edge and reads the outputs at the next falling edge. Counter effects cannot be seen directly, so the bench observes them through timing: it counts how many hits in a row an entry needs before it is promoted. A demoted entry must be promoted after exactly six further hits, and an aged entry must need three more hits than an unaged one. The halving is applied on the 64th access itself, so the bench counts accesses from reset and checks the hits that follow that access.

// File: rtl/lfru_pkg.sv
`timescale 1ns/1ps
package lfru_pkg;
    localparam int unsigned LFRU_ID_W = 16;

    typedef logic [LFRU_ID_W-1:0] cid_t;

    typedef struct packed {
        logic vld;
        cid_t id;
    } slot_t;

    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_MISS    = 3'd1,
        ACT_OHIT    = 3'd2,
        ACT_PHIT    = 3'd3,
        ACT_PROMOTE = 3'd4
    } act_e;

    function automatic logic holds(slot_t s, cid_t id);
        return s.vld && (s.id == id);
    endfunction
endpackage

// File: rtl/lfru_lru_order.sv
`timescale 1ns/1ps
module lfru_lru_order #(
    parameter int unsigned NPRIV = 4,
    localparam int unsigned PW = (NPRIV > 1) ? $clog2(NPRIV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPRIV-1:0] valid_i,
    input  logic             touch_en_i,
    input  logic [PW-1:0]    touch_idx_i,
    output logic [PW-1:0]    victim_o
);
    // rank 0 is most recent, NPRIV-1 is least recent
    logic [NPRIV-1:0][PW-1:0] rank_q;

    always_comb begin
        logic found;
        found    = 1'b0;
        victim_o = '0;
        for (int i = 0; i < NPRIV; i++) begin
            if (!found && !valid_i[i]) begin
                victim_o = PW'(i);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NPRIV; i++) begin
                if (rank_q[i] == PW'(NPRIV-1)) victim_o = PW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPRIV; i++) rank_q[i] <= PW'(i);
        end else if (touch_en_i) begin
            for (int i = 0; i < NPRIV; i++) begin
                if (PW'(i) == touch_idx_i)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx_i])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // R7: a touched slot becomes most recent
    p_touch_mru_r7: assert property (@(posedge clk) disable iff (rst)
        touch_en_i |=> rank_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/lfru_freq_table.sv
`timescale 1ns/1ps
module lfru_freq_table #(
    parameter int unsigned NUNP  = 8,
    parameter int unsigned CNT_W = 3,
    localparam int unsigned UW = (NUNP > 1) ? $clog2(NUNP) : 1,
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}}
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       inc_en_i,
    input  logic [UW-1:0]              inc_idx_i,
    input  logic                       load_en_i,
    input  logic [UW-1:0]              load_idx_i,
    input  logic [CNT_W-1:0]           load_val_i,
    input  logic                       age_en_i,
    output logic [NUNP-1:0][CNT_W-1:0] cnt_o,
    output logic [UW-1:0]              min_idx_o
);
    logic [NUNP-1:0][CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_en_i && cnt_q[inc_idx_i] != CMAX)
            cnt_d[inc_idx_i] = cnt_q[inc_idx_i] + 1'b1;
        if (load_en_i)
            cnt_d[load_idx_i] = load_val_i;
        if (age_en_i)
            for (int j = 0; j < NUNP; j++) cnt_d[j] = cnt_d[j] >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    always_comb begin
        logic [CNT_W-1:0] best;
        best      = cnt_q[0];
        min_idx_o = '0;
        for (int j = 1; j < NUNP; j++) begin
            if (cnt_q[j] < best) begin
                best      = cnt_q[j];
                min_idx_o = UW'(j);
            end
        end
    end

    assign cnt_o = cnt_q;

    // R8: after an aging step no counter exceeds half range
    for (genvar g = 0; g < NUNP; g++) begin : g_age_chk
        p_age_halves_r8: assert property (@(posedge clk) disable iff (rst)
            age_en_i |=> cnt_q[g] <= (CMAX >> 1));
    end

    // R4: an increment without aging or reload adds exactly one
    p_inc_one_r4: assert property (@(posedge clk) disable iff (rst)
        (inc_en_i && !age_en_i && !load_en_i && cnt_q[inc_idx_i] != CMAX)
        |=> cnt_q[$past(inc_idx_i)] == $past(cnt_q[inc_idx_i]) + 1'b1);

    // R3: a load without aging installs the requested value
    p_load_val_r3: assert property (@(posedge clk) disable iff (rst)
        (load_en_i && !age_en_i) |=> cnt_q[$past(load_idx_i)] == $past(load_val_i));
endmodule

// File: rtl/lfru_ctrl.sv
`timescale 1ns/1ps
module lfru_ctrl
    import lfru_pkg::*;
#(
    parameter int unsigned NPRIV      = 4,
    parameter int unsigned NUNP       = 8,
    parameter int unsigned CNT_W      = 3,
    parameter int unsigned AGE_PERIOD = 64,
    localparam int unsigned PW = (NPRIV > 1) ? $clog2(NPRIV) : 1,
    localparam int unsigned UW = (NUNP > 1) ? $clog2(NUNP) : 1,
    localparam int unsigned SW = $clog2(NPRIV + NUNP),
    localparam int unsigned AW = (AGE_PERIOD > 1) ? $clog2(AGE_PERIOD) : 1,
    localparam logic [CNT_W-1:0] CTOP = {CNT_W{1'b1}} - 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [LFRU_ID_W-1:0] acc_id,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic                 res_in_priv,
    output logic [SW-1:0]        res_slot,
    output logic                 res_promote,
    output logic                 res_evict,
    output logic                 res_demote,
    output logic [LFRU_ID_W-1:0] res_out_id
);
    slot_t [NPRIV-1:0] pslot_q;
    slot_t [NUNP-1:0]  oslot_q;
    logic  [AW-1:0]    age_q;

    logic [NPRIV-1:0] p_match, p_vld;
    logic [NUNP-1:0]  o_match;
    logic [PW-1:0]    p_idx, vic;
    logic [UW-1:0]    o_idx, min_idx;
    logic [NUNP-1:0][CNT_W-1:0] cnt;
    slot_t vic_slot;
    act_e  act;
    logic  age_en;

    always_comb begin
        for (int i = 0; i < NPRIV; i++) begin
            p_match[i] = holds(pslot_q[i], acc_id);
            p_vld[i]   = pslot_q[i].vld;
        end
        for (int j = 0; j < NUNP; j++) o_match[j] = holds(oslot_q[j], acc_id);
        p_idx = '0;
        for (int i = NPRIV-1; i >= 0; i--) if (p_match[i]) p_idx = PW'(i);
        o_idx = '0;
        for (int j = NUNP-1; j >= 0; j--) if (o_match[j]) o_idx = UW'(j);
    end

    assign vic_slot = pslot_q[vic];

    always_comb begin
        if (!acc_valid)          act = ACT_IDLE;
        else if (|p_match)       act = ACT_PHIT;
        else if (!(|o_match))    act = ACT_MISS;
        else if (cnt[o_idx] == CTOP) act = ACT_PROMOTE;
        else                     act = ACT_OHIT;
    end

    assign age_en = acc_valid && (age_q == AW'(AGE_PERIOD-1));

    lfru_lru_order #(.NPRIV(NPRIV)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (p_vld),
        .touch_en_i (act == ACT_PHIT || act == ACT_PROMOTE),
        .touch_idx_i((act == ACT_PHIT) ? p_idx : vic),
        .victim_o   (vic)
    );

    lfru_freq_table #(.NUNP(NUNP), .CNT_W(CNT_W)) u_freq (
        .clk        (clk),
        .rst        (rst),
        .inc_en_i   (act == ACT_OHIT),
        .inc_idx_i  (o_idx),
        .load_en_i  (act == ACT_MISS || act == ACT_PROMOTE),
        .load_idx_i ((act == ACT_PROMOTE) ? o_idx : min_idx),
        .load_val_i ((act == ACT_PROMOTE && !vic_slot.vld) ? CNT_W'(0) : CNT_W'(1)),
        .age_en_i   (age_en),
        .cnt_o      (cnt),
        .min_idx_o  (min_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pslot_q <= '0;
            oslot_q <= '0;
            age_q   <= '0;
        end else if (acc_valid) begin
            age_q <= age_en ? '0 : age_q + 1'b1;
            if (act == ACT_PROMOTE) begin
                pslot_q[vic]   <= oslot_q[o_idx];
                oslot_q[o_idx] <= vic_slot;
            end else if (act == ACT_MISS) begin
                oslot_q[min_idx] <= '{vld: 1'b1, id: acc_id};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_in_priv <= 1'b0;
            res_slot    <= '0;
            res_promote <= 1'b0;
            res_evict   <= 1'b0;
            res_demote  <= 1'b0;
            res_out_id  <= '0;
        end else begin
            res_valid   <= acc_valid;
            res_hit     <= act inside {ACT_PHIT, ACT_OHIT, ACT_PROMOTE};
            res_in_priv <= act == ACT_PHIT;
            res_promote <= act == ACT_PROMOTE;
            res_evict   <= act == ACT_MISS && oslot_q[min_idx].vld;
            res_demote  <= act == ACT_PROMOTE && vic_slot.vld;
            res_out_id  <= '0;
            res_slot    <= '0;
            case (act)
                ACT_PHIT:    res_slot <= SW'(p_idx);
                ACT_PROMOTE: begin
                    res_slot   <= SW'(vic);
                    res_out_id <= vic_slot.vld ? vic_slot.id : '0;
                end
                ACT_OHIT:    res_slot <= SW'(NPRIV) + SW'(o_idx);
                ACT_MISS:    begin
                    res_slot   <= SW'(NPRIV) + SW'(min_idx);
                    res_out_id <= oslot_q[min_idx].vld ? oslot_q[min_idx].id : '0;
                end
                default: ;
            endcase
        end
    end

    // R2: one result per access, none otherwise
    p_result_due_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);
    // R9: an identifier sits in at most one slot
    p_single_home_r9: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $onehot0({p_match, o_match}));
    // R5: a promotion always lands in the protected range
    p_promote_priv_r5: assert property (@(posedge clk) disable iff (rst)
        res_promote |-> (res_slot < SW'(NPRIV)) && res_hit);
    // R3: eviction is a miss-only event
    p_evict_on_miss_r3: assert property (@(posedge clk) disable iff (rst)
        res_evict |-> !res_hit);
endmodule

// File: tb/test_lfru_ctrl.sv
`timescale 1ns/1ps
module test_lfru_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_id = '0;
    logic        res_valid, res_hit, res_in_priv, res_promote, res_evict, res_demote;
    logic [3:0]  res_slot;
    logic [15:0] res_out_id;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lfru_ctrl i_lfru_ctrl (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_id(acc_id),
        .res_valid(res_valid), .res_hit(res_hit), .res_in_priv(res_in_priv),
        .res_slot(res_slot), .res_promote(res_promote), .res_evict(res_evict),
        .res_demote(res_demote), .res_out_id(res_out_id)
    );

    typedef struct packed {
        logic [15:0] id;
        logic [3:0]  rep;
        logic        hit;
        logic        priv;
        logic [3:0]  slot;
        logic        prom;
        logic        ev;
        logic        dm;
        logic [15:0] xid;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{16'h0A01, 4'd1, 1'b0, 1'b0, 4'd4,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0B02, 4'd1, 1'b0, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0A01, 4'd5, 1'b1, 1'b0, 4'd4,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0A01, 4'd1, 1'b1, 1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 16'h0000},
        '{16'h0A01, 4'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0C03, 4'd1, 1'b0, 1'b0, 4'd4,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0D04, 4'd1, 1'b0, 1'b0, 4'd6,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0E05, 4'd1, 1'b0, 1'b0, 4'd7,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0F06, 4'd1, 1'b0, 1'b0, 4'd8,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h1007, 4'd1, 1'b0, 1'b0, 4'd9,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h1108, 4'd1, 1'b0, 1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h1209, 4'd1, 1'b0, 1'b0, 4'd11, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0B02, 4'd1, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h130A, 4'd1, 1'b0, 1'b0, 4'd4,  1'b0, 1'b1, 1'b0, 16'h0C03},
        '{16'h130A, 4'd1, 1'b1, 1'b0, 4'd4,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h140B, 4'd1, 1'b0, 1'b0, 4'd6,  1'b0, 1'b1, 1'b0, 16'h0D04},
        '{16'h0B02, 4'd4, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0B02, 4'd1, 1'b1, 1'b0, 4'd1,  1'b1, 1'b0, 1'b0, 16'h0000},
        '{16'h150C, 4'd1, 1'b0, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h150C, 4'd5, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h150C, 4'd1, 1'b1, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 16'h0000},
        '{16'h160D, 4'd1, 1'b0, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h160D, 4'd5, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h160D, 4'd1, 1'b1, 1'b0, 4'd3,  1'b1, 1'b0, 1'b0, 16'h0000},
        '{16'h0A01, 4'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h170E, 4'd1, 1'b0, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h170E, 4'd5, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h170E, 4'd1, 1'b1, 1'b0, 4'd1,  1'b1, 1'b0, 1'b1, 16'h0B02},
        '{16'h0B02, 4'd5, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000},
        '{16'h0B02, 4'd1, 1'b1, 1'b0, 4'd2,  1'b1, 1'b0, 1'b1, 16'h150C},
        '{16'h150C, 4'd1, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic access(input logic [15:0] id);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_id    = id;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
        chk("R1 res_hit after reset", 32'(res_hit), 32'd0);

        for (int r = 0; r < NV; r++) begin
            for (int k = 0; k < int'(TBL[r].rep); k++) begin
                access(TBL[r].id);
                chk($sformatf("R2 valid row %0d", r), 32'(res_valid), 32'd1);
                chk($sformatf("R3 hit row %0d", r), 32'(res_hit), 32'(TBL[r].hit));
                chk($sformatf("R7 region row %0d", r), 32'(res_in_priv), 32'(TBL[r].priv));
                chk($sformatf("R10 slot row %0d", r), 32'(res_slot), 32'(TBL[r].slot));
                chk($sformatf("R4 R5 promote row %0d", r), 32'(res_promote), 32'(TBL[r].prom));
                chk($sformatf("R3 evict row %0d", r), 32'(res_evict), 32'(TBL[r].ev));
                chk($sformatf("R6 demote row %0d", r), 32'(res_demote), 32'(TBL[r].dm));
                chk($sformatf("R6 out id row %0d", r), 32'(res_out_id), 32'(TBL[r].xid));
            end
        end

        // R9: the demoted identifier lives only in the open region
        access(16'h150C);
        chk("R9 single home hit", 32'(res_hit), 32'd1);
        chk("R9 single home region", 32'(res_in_priv), 32'd0);

        // R2: an idle cycle yields no result
        @(negedge clk);
        chk("R2 idle no result", 32'(res_valid), 32'd0);

        // R1: reset forgets all content
        do_reset();
        chk("R1 res_valid cleared", 32'(res_valid), 32'd0);
        access(16'h0A01);
        chk("R1 former protected id misses", 32'(res_hit), 32'd0);
        chk("R1 first fill slot", 32'(res_slot), 32'd4);
        chk("R1 no eviction", 32'(res_evict), 32'd0);

        // R8: aging on the 64th access
        do_reset();
        access(16'h3000);
        for (int k = 0; k < 5; k++) access(16'h3000);
        for (int k = 0; k < 58; k++) access(16'h4000 + 16'(k));
        chk("R8 filler never evicts hot slot", 32'(res_slot == 4'd4), 32'd0);
        access(16'h3000);
        chk("R8 aged counter no promote 1", 32'(res_promote), 32'd0);
        chk("R8 aged hit slot", 32'(res_slot), 32'd4);
        access(16'h3000);
        access(16'h3000);
        chk("R8 aged counter no promote 3", 32'(res_promote), 32'd0);
        access(16'h3000);
        chk("R8 promote after regrowth", 32'(res_promote), 32'd1);
        chk("R5 promote into first empty", 32'(res_slot), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule